// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a simple synchronous host port and an asynchronous 512K x 16 static RAM. It turns each accepted host read or write into a strobe sequence for the memory. The memory has one chip select that is active low and one that is active high, a low-active enable for each byte lane, a write strobe, an output enable and a shared 16-bit data bus. Inside the chip that bus appears as separate input, output and output-enable signals. The length of every strobe phase is worked out at elaboration time from nanosecond timing parameters and the clock period, always rounding up. A single down-counter then times each phase out.

The host sees `req_ready` only while the controller is idle. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. A read returns its data with a one-cycle `rsp_valid` pulse. A write needs no response and is complete once `req_ready` comes back. After reset the controller keeps the memory deselected for a power-up hold-off plus a recovery time before it accepts any request. After each read it leaves a bus-release gap so the memory can stop driving before the controller drives the bus again.

Top module: `sram_ctl`

## Requirements
- R1: Whenever no access is in progress (during reset, the power-up wait, idle and turnaround), both chip selects are inactive (`mem_cs_n`=1, `mem_cs`=0), `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: Once reset is released, `req_ready` stays low for exactly ceil(T_PWRUP_NS/CLK_NS)+ceil(T_REC_NS/CLK_NS)+2 clock edges. The +2 covers the reset synchronizer. After that it rises.
- R3: A read with a non-zero mask holds both chip selects active, `mem_oe_n` low and `mem_we_n` high for RD_CYC = max(ceil(T_RC), ceil(T_AA), ceil(T_DOE)) cycles. Data is captured on the last of those cycles. `rsp_valid` is high for one cycle, on the first cycle after the read phase ends.
- R4: Byte lanes map as follows: mask bit 0 is data bits 7:0 and drives `mem_lane_n[0]`, and mask bit 1 is bits 15:8 and drives `mem_lane_n[1]`. While the memory is selected, `mem_lane_n` equals the inverted mask. In read data, a lane whose mask bit is 0 returns zero.
- R5: A write with a non-zero mask holds `mem_we_n` low for exactly WP_CYC = max(ceil(T_PWE), ceil(T_SD), ceil(T_AW)-1) consecutive cycles.
- R6: While `mem_we_n` is low, `mem_dq_oe` is high, and `mem_dq_o` carries the request's write data. Both `mem_dq_o` and `mem_addr` stay stable.
- R7: After `mem_oe_n` rises, `mem_dq_oe` stays low for at least TA_CYC = ceil(T_HZ_NS) cycles. After a read, `req_ready` returns TA_CYC cycles after the capture cycle.
- R8: A request whose mask is all zero asserts neither chip select, write strobe nor output enable. A zero-mask read returns zero data with `rsp_valid` on the cycle right after it is accepted. In both cases `req_ready` stays high.
- R9: A write keeps the memory selected for one setup cycle, then the write pulse, then a hold of max(1, ceil(T_WC)-1-WP_CYC) cycles. `req_ready` returns on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte lane mask, bit 0 = bits 7:0 |
| req_ready | output | 1 | Controller idle, request accepted this edge if valid |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data, disabled lanes zero |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | DATA_W/8 | Byte lane enables, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | DATA_W | Data returned from memory |

## Verification
When `req_ready` comes back after reset release, that count is checked edge for edge. For each request, the bench counts sampled cycles from the accepting edge. With a 4 ns clock it expects `rsp_valid` at sample RD_CYC+1 (13) and the next ready at RD_CYC+TA_CYC+1 (18) for a read. A write should show 9 write-strobe cycles inside 12 selected cycles, with ready at sample 13. A zero-mask request should show ready and, for a read, `rsp_valid` at sample 1. All port samples are taken on the falling edge. Each value is therefore read half a cycle after the rising edge that set it, and the per-request counts are compared with the cycle counts the requirements give.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_INIT = 3'd0,
    ST_IDLE = 3'd1,
    ST_RD   = 3'd2,
    ST_WSET = 3'd3,
    ST_WPUL = 3'd4,
    ST_WHLD = 3'd5,
    ST_TURN = 3'd6
  } ctl_st_e;

  // Round a time up to whole clock cycles, never fewer than one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_rstsync.sv
module sram_ctl_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic ff1, ff2;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ff1 <= 1'b0;
      ff2 <= 1'b0;
    end else begin
      ff1 <= 1'b1;
      ff2 <= ff1;
    end
  end

  assign srst_n = ff2;
endmodule

// File: rtl/sram_ctl_cnt.sv
module sram_ctl_cnt #(
  parameter int            W       = 8,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = ld | ~zero;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)         cnt_d = ld_val;
    else if (!zero) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RST_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int CW     = 16,
  parameter int RD_CYC = 12,
  parameter int WS_CYC = 1,
  parameter int WP_CYC = 9,
  parameter int WH_CYC = 2,
  parameter int TA_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  input  logic             cnt_zero,
  output logic             cnt_ld,
  output logic [CW-1:0]    cnt_val,
  output logic             accept,
  output logic             zero_rd,
  output logic             capture,
  output logic             ready,
  output logic             sel_q,
  output logic             oe_q,
  output logic             we_q,
  output logic             drv_q
);
  localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WS_LD = CW'(WS_CYC - 1);
  localparam logic [CW-1:0] WP_LD = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] WH_LD = CW'(WH_CYC - 1);
  localparam logic [CW-1:0] TA_LD = CW'(TA_CYC - 1);

  ctl_st_e st_q, st_d;
  logic    sel_d, oe_d, we_d, drv_d;
  logic    mask_zero;

  assign mask_zero = (req_be == '0);
  assign ready     = (st_q == ST_IDLE);
  assign accept    = ready & req_valid;
  assign zero_rd   = accept & ~req_write & mask_zero;
  assign capture   = (st_q == ST_RD) & cnt_zero;

  always_comb begin
    st_d    = st_q;
    cnt_ld  = 1'b0;
    cnt_val = '0;
    unique case (st_q)
      ST_INIT: if (cnt_zero) st_d = ST_IDLE;
      ST_IDLE: begin
        if (req_valid && !mask_zero) begin
          cnt_ld = 1'b1;
          if (req_write) begin
            st_d    = ST_WSET;
            cnt_val = WS_LD;
          end else begin
            st_d    = ST_RD;
            cnt_val = RD_LD;
          end
        end
      end
      ST_RD: if (cnt_zero) begin
        st_d = ST_TURN; cnt_ld = 1'b1; cnt_val = TA_LD;
      end
      ST_WSET: if (cnt_zero) begin
        st_d = ST_WPUL; cnt_ld = 1'b1; cnt_val = WP_LD;
      end
      ST_WPUL: if (cnt_zero) begin
        st_d = ST_WHLD; cnt_ld = 1'b1; cnt_val = WH_LD;
      end
      ST_WHLD: if (cnt_zero) st_d = ST_IDLE;
      ST_TURN: if (cnt_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // Strobes are decoded from the next state and registered with it.
  always_comb begin
    sel_d = (st_d == ST_RD) | (st_d == ST_WSET) | (st_d == ST_WPUL) | (st_d == ST_WHLD);
    oe_d  = (st_d == ST_RD);
    we_d  = (st_d == ST_WPUL);
    drv_d = (st_d == ST_WSET) | (st_d == ST_WPUL) | (st_d == ST_WHLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_INIT;
      sel_q <= 1'b0;
      oe_q  <= 1'b0;
      we_q  <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
      oe_q  <= oe_d;
      we_q  <= we_d;
      drv_q <= drv_d;
    end
  end
endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              zero_rd,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  be_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rsp_q
);
  logic [DATA_W-1:0] lane_mask;
  logic              rd_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
  end

  assign rd_en = capture | zero_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= rd_en;
      if (rd_en) rdata_q <= capture ? (mem_dq_i & lane_mask) : '0;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 16,
  parameter int CLK_NS     = 4,
  parameter int T_RC_NS    = 45,
  parameter int T_AA_NS    = 45,
  parameter int T_DOE_NS   = 22,
  parameter int T_WC_NS    = 45,
  parameter int T_PWE_NS   = 35,
  parameter int T_SD_NS    = 25,
  parameter int T_AW_NS    = 35,
  parameter int T_HZ_NS    = 18,
  parameter int T_REC_NS   = 45,
  parameter int T_PWRUP_NS = 200000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  req_ready,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  mem_cs_n,
  output logic                  mem_cs,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic [DATA_W/8-1:0]   mem_lane_n,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_dq_o,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_i
);
  localparam int LANES    = DATA_W / 8;
  localparam int RD_CYC   = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                 ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int WS_CYC   = 1;
  localparam int WP_CYC   = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                                 ns_to_cyc(T_AW_NS, CLK_NS) - WS_CYC);
  localparam int WH_CYC   = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - WS_CYC - WP_CYC);
  localparam int TA_CYC   = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int INIT_CYC = ns_to_cyc(T_PWRUP_NS, CLK_NS) + ns_to_cyc(T_REC_NS, CLK_NS);
  localparam int CNT_MAX  = imax(imax(INIT_CYC, RD_CYC), imax(WP_CYC, imax(WH_CYC, TA_CYC)));
  localparam int CW       = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] INIT_LD = CW'(INIT_CYC - 1);

  logic            srst_n;
  logic            cnt_ld, cnt_zero;
  logic [CW-1:0]   cnt_val;
  logic            accept, zero_rd, capture;
  logic            sel_q, oe_q, we_q, drv_q;
  logic [LANES-1:0] be_q;

  sram_ctl_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sram_ctl_cnt #(.W(CW), .RST_VAL(INIT_LD)) u_cnt (
    .clk    (clk),
    .rst_n  (srst_n),
    .ld     (cnt_ld),
    .ld_val (cnt_val),
    .zero   (cnt_zero)
  );

  sram_ctl_fsm #(
    .LANES (LANES), .CW (CW), .RD_CYC (RD_CYC), .WS_CYC (WS_CYC),
    .WP_CYC (WP_CYC), .WH_CYC (WH_CYC), .TA_CYC (TA_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_be    (req_be),
    .cnt_zero  (cnt_zero),
    .cnt_ld    (cnt_ld),
    .cnt_val   (cnt_val),
    .accept    (accept),
    .zero_rd   (zero_rd),
    .capture   (capture),
    .ready     (req_ready),
    .sel_q     (sel_q),
    .oe_q      (oe_q),
    .we_q      (we_q),
    .drv_q     (drv_q)
  );

  sram_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk       (clk),
    .rst_n     (srst_n),
    .accept    (accept),
    .zero_rd   (zero_rd),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .mem_dq_i  (mem_dq_i),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_o),
    .be_q      (be_q),
    .rdata_q   (rsp_rdata),
    .rsp_q     (rsp_valid)
  );

  assign mem_cs_n   = ~sel_q;
  assign mem_cs     = sel_q;
  assign mem_oe_n   = ~oe_q;
  assign mem_we_n   = ~we_q;
  assign mem_dq_oe  = drv_q;
  assign mem_lane_n = ~(be_q & {LANES{sel_q}});
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int WP_CYC = 9,
  parameter int TA_CYC = 5
) (
  input logic              clk,
  input logic              srst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_lane_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);
  localparam int LW = $clog2(WP_CYC + 1) + 1;
  localparam int TW = $clog2(TA_CYC + 1) + 1;

  logic [LW-1:0] we_low_cnt;
  logic [TW-1:0] oe_gap_cnt;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      we_low_cnt <= '0;
      oe_gap_cnt <= TW'(TA_CYC);
    end else begin
      if (mem_we_n)                       we_low_cnt <= '0;
      else if (we_low_cnt != LW'(WP_CYC)) we_low_cnt <= we_low_cnt + 1'b1;
      if (!mem_oe_n)                      oe_gap_cnt <= '0;
      else if (oe_gap_cnt != TW'(TA_CYC)) oe_gap_cnt <= oe_gap_cnt + 1'b1;
    end
  end

  // R1
  p_idle_desel_r1: assert property (@(posedge clk) disable iff (!srst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));
  // R3
  p_we_oe_excl_r3: assert property (@(posedge clk) disable iff (!srst_n)
    !(!mem_we_n && !mem_oe_n));
  // R3: response appears only while the memory is released
  p_rsp_desel_r3: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_valid |-> mem_cs_n);
  // R5
  p_we_width_r5: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(mem_we_n) |-> (we_low_cnt >= LW'(WP_CYC)));
  // R6
  p_we_data_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (!mem_we_n && !$rose(!mem_we_n)) |->
      (mem_dq_oe && $stable(mem_dq_o) && $stable(mem_addr)));
  // R6: drive enable always present under the write strobe
  p_we_drive_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !mem_we_n |-> mem_dq_oe);
  // R7
  p_oe_nodrive_r7: assert property (@(posedge clk) disable iff (!srst_n)
    !mem_oe_n |-> !mem_dq_oe);
  // R7
  p_ta_gap_r7: assert property (@(posedge clk) disable iff (!srst_n)
    mem_dq_oe |-> (oe_gap_cnt >= TW'(TA_CYC)));
  // R8
  p_strobe_lane_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (!mem_we_n || !mem_oe_n) |-> (mem_lane_n != '1));
endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LANES (LANES),
  .WP_CYC (WP_CYC), .TA_CYC (TA_CYC)
) u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_cs_n   (mem_cs_n),
  .mem_cs     (mem_cs),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_lane_n (mem_lane_n),
  .mem_addr   (mem_addr),
  .mem_dq_o   (mem_dq_o),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_ctl.sv
`timescale 1ns/1ps
module test_sram_ctl;
  localparam int CLK   = 4;
  localparam int PWRUP = 200;

  function automatic int cyc(input int ns);
    return (ns + CLK - 1) / CLK;
  endfunction

  localparam int RDC   = (cyc(45) > cyc(22)) ? cyc(45) : cyc(22);
  localparam int WPC   = (cyc(35) > cyc(25)) ? cyc(35) : cyc(25);
  localparam int WCC   = cyc(45);
  localparam int TAC   = cyc(18);
  localparam int INITC = cyc(PWRUP) + cyc(45) + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [18:0] mem_addr;
  logic [15:0] mem_dq_o, mem_dq_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] expq[$];
  logic [15:0] shadow [64];
  logic [15:0] marr [64];

  always #(CLK/2) clk = ~clk;

  sram_ctl #(.CLK_NS(CLK), .T_PWRUP_NS(PWRUP)) i_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lane_n(mem_lane_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // Memory model: selected means active-low select low and active-high select high.
  logic sel_m;
  assign sel_m = !mem_cs_n && mem_cs;
  always_comb begin
    mem_dq_i = 16'hDEAD;
    if (sel_m && !mem_oe_n && mem_we_n) begin
      mem_dq_i[7:0]  = !mem_lane_n[0] ? marr[mem_addr[5:0]][7:0]  : 8'hC3;
      mem_dq_i[15:8] = !mem_lane_n[1] ? marr[mem_addr[5:0]][15:8] : 8'hC3;
    end
  end

  logic prev_we = 1'b1;
  always @(negedge clk) begin
    if (!prev_we && mem_we_n && sel_m && mem_dq_oe) begin
      if (!mem_lane_n[0]) marr[mem_addr[5:0]][7:0]  = mem_dq_o[7:0];
      if (!mem_lane_n[1]) marr[mem_addr[5:0]][15:8] = mem_dq_o[15:8];
    end
    prev_we = mem_we_n;
  end

  // Scoreboard monitor for read responses.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) chk(1'b0, "R3 unexpected rsp_valid", 1, 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(rsp_rdata == e, "R4 read data", rsp_rdata, e);
      end
    end
  end

  // Turnaround monitor: cycles since output enable was last low.
  int since_oe = 99;
  logic prev_oe_drv = 1'b0;
  always @(negedge clk) begin
    if (!mem_oe_n) since_oe = 0;
    else if (since_oe < 99) since_oe++;
    if (mem_dq_oe && !prev_oe_drv) chk(since_oe > TAC, "R7 drive gap after oe_n rise", since_oe, TAC + 1);
    prev_oe_drv = mem_dq_oe;
  end

  task automatic do_req(input bit wr, input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
    int n_sel, n_oe, n_we, rsp_i, rdy_i;
    bit data_ok, lane_ok;
    logic [15:0] m;
    n_sel = 0; n_oe = 0; n_we = 0; rsp_i = 0; rdy_i = 0;
    data_ok = 1'b1; lane_ok = 1'b1;
    m = {{8{be[1]}}, {8{be[0]}}};
    while (!req_ready) @(negedge clk);
    if (!wr) expq.push_back(shadow[a[5:0]] & m);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 1; i < 1000; i++) begin
      if (sel_m) begin
        n_sel++;
        if (mem_lane_n != ~be) lane_ok = 1'b0;
      end
      if (!mem_oe_n) n_oe++;
      if (!mem_we_n) begin
        n_we++;
        if (!mem_dq_oe || mem_dq_o != d || mem_addr != a) data_ok = 1'b0;
      end
      if (rsp_valid && rsp_i == 0) rsp_i = i;
      if (req_ready) begin
        rdy_i = i;
        break;
      end
      @(negedge clk);
    end
    if (be == 2'b00) begin
      chk(n_sel == 0 && n_we == 0 && n_oe == 0, "R8 no strobes on zero mask", n_sel + n_we + n_oe, 0);
      chk(rdy_i == 1, "R8 ready stays high", rdy_i, 1);
      if (!wr) chk(rsp_i == 1, "R8 zero read response cycle", rsp_i, 1);
    end else if (wr) begin
      if (mem_lane_n[0]) shadow[a[5:0]][7:0]  = be[0] ? d[7:0]  : shadow[a[5:0]][7:0];
      if (mem_lane_n[1]) shadow[a[5:0]][15:8] = be[1] ? d[15:8] : shadow[a[5:0]][15:8];
      chk(n_we == WPC, "R5 write pulse cycles", n_we, WPC);
      chk(data_ok, "R6 data and address under strobe", data_ok, 1);
      chk(lane_ok, "R4 write lane enables", lane_ok, 1);
      chk(n_sel == WCC, "R9 selected cycles of write", n_sel, WCC);
      chk(rdy_i == WCC + 1, "R9 ready after write", rdy_i, WCC + 1);
      chk(n_oe == 0, "R3 no output enable in write", n_oe, 0);
    end else begin
      chk(n_oe == RDC, "R3 output enable cycles", n_oe, RDC);
      chk(n_we == 0, "R3 no write strobe in read", n_we, 0);
      chk(rsp_i == RDC + 1, "R3 response cycle", rsp_i, RDC + 1);
      chk(lane_ok, "R4 read lane enables", lane_ok, 1);
      chk(rdy_i == RDC + TAC + 1, "R7 ready after turnaround", rdy_i, RDC + TAC + 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int n;
    for (int k = 0; k < 64; k++) begin
      shadow[k] = '0;
      marr[k]   = '0;
    end
    repeat (3) @(negedge clk);
    chk(sel_m == 0 && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready,
        "R1 reset state", {sel_m, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b01100);
    rst_n = 1'b1;
    n = 0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      n++;
      if (sel_m || !mem_we_n || !mem_oe_n || mem_dq_oe) chk(1'b0, "R1 strobe during hold-off", 1, 0);
      if (req_ready) break;
    end
    chk(n == INITC, "R2 hold-off length", n, INITC);
    chk(mem_cs_n && !mem_cs, "R1 idle deselected", {mem_cs_n, mem_cs}, 2'b10);

    do_req(1'b1, 19'h00001, 16'h1234, 2'b11);
    do_req(1'b0, 19'h00001, 16'h0000, 2'b11);
    do_req(1'b1, 19'h00002, 16'hAAAA, 2'b11);
    do_req(1'b1, 19'h00002, 16'h5566, 2'b01);
    do_req(1'b0, 19'h00002, 16'h0000, 2'b11);
    do_req(1'b0, 19'h00002, 16'h0000, 2'b10);
    do_req(1'b0, 19'h00002, 16'h0000, 2'b01);
    do_req(1'b1, 19'h7FFFF, 16'hBEEF, 2'b10);
    do_req(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
    do_req(1'b1, 19'h00002, 16'hFFFF, 2'b00);
    do_req(1'b0, 19'h00002, 16'h0000, 2'b11);
    do_req(1'b0, 19'h00001, 16'h0000, 2'b00);
    do_req(1'b1, 19'h00001, 16'h0F0F, 2'b11);
    do_req(1'b0, 19'h00001, 16'h0000, 2'b11);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R3 all reads answered", expq.size(), 0);
    chk(!mem_dq_oe && mem_cs_n, "R1 idle after traffic", {mem_dq_oe, mem_cs_n}, 2'b01);
    summary();
  end
endmodule